// File: doc/BRIEF.md
# Six-Channel PWM Period Timebase

This block provides the period timebase for six PWM channels, controlled through a byte-wide register port. Each channel owns an up-counter and a 16-bit period value. Shared control registers hold one bit per channel and select the counting mode, enable the counter, and request a counter restart. Software programs a period, chooses a mode and sets the enable bit. The channel then raises a one-cycle match pulse each time its count reaches the period.

Hardware also changes control state by itself. A brake input drops every enable bit at once. A channel in one-shot mode drops its own enable bit after its single period completes. A restart request bit returns to zero one cycle after it is written.

Each channel runs a two-state controller. The states are CH_IDLE (count held at zero) and CH_RUN (counting). The transitions are:
- IDLE->RUN: the enable bit is 1 and brake is low.
- RUN->IDLE on stop: brake is high, or the enable bit is 0.
- RUN->IDLE on finish: the count equals the period in one-shot mode.
- RUN->RUN on wrap: the count equals the period in auto-reload mode, and the count returns to 0.
- RUN->RUN on restart: the restart bit is set, and the count returns to 0.
- RUN->RUN on advance: none of the above, and the count increments.

Top module: `pwm6_timebase`

## Requirements
- R1: Register map: mode at 0x00, enable at 0x01, restart at 0x02, period low byte of channel n at 0x10+2n, high byte at 0x11+2n. Bit n of a control register belongs to channel n. Bits 7..6 of the control registers always read 0 and ignore writes. Every register resets to 0.
- R2: A mode bit of 1 selects auto-reload: after a match the count returns to 0 and the channel keeps running. The match then repeats every period+1 cycles.
- R3: Writing an enable bit to 1 sets `running_o` for that channel one clock after the write edge, with the count starting from 0.
- R4: `match_o[n]` is high for exactly the one cycle in which the running count equals the period. With period P, this is P cycles after `running_o[n]` rises.
- R5: A mode bit of 0 selects one-shot: at the edge after the match, the enable bit clears and `running_o` falls.
- R6: Software writing an enable bit to 0 suppresses `match_o` from the write edge onward. `running_o` falls one clock later. A later enable counts again from 0.
- R7: At any edge where `brake_i` is high, all enable bits clear and all `running_o` fall. An enable write at that same edge is lost.
- R8: Writing 1 to a restart bit zeroes that channel's count at the following edge. The bit reads 1 for one cycle and then reads 0 by itself. Writing 0 to it changes nothing.
- R9: A period low-byte write is staged and is not visible. The following high-byte write commits both bytes together.
- R10: A period of 0 gives a match on every cycle while the channel runs.
- R11: When a one-shot completion and a software write of enable=1 land on the same edge, the hardware clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, sampled at the rising edge |
| addr_i | input | 8 | Register address for writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| brake_i | input | 1 | Brake: stops every channel |
| match_o | output | 6 | Per-channel period-match pulse |
| running_o | output | 6 | Per-channel counting flag |

## Verification
A write takes effect at the edge that samples it, so register readback is checked half a cycle after that edge. `running_o` follows an enable write one edge later. The first match therefore falls P edges after that, and auto-reload repeats every P+1 edges. Each task advances exactly that many falling edges before sampling. Brake and one-shot completion act at the sampled edge itself. Restart requests act one edge after the write, so their checks sample at the falling edge that follows each of those points.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

    localparam int BYTE_W    = 8;
    localparam int PERIOD_W  = 16;
    localparam int A_MODE    = 'h00;
    localparam int A_ENABLE  = 'h01;
    localparam int A_RESTART = 'h02;
    localparam int A_PERBASE = 'h10;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/pwm6_regfile.sv
module pwm6_regfile
    import pwm6_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 8,
    parameter int DW     = BYTE_W,
    parameter int PW     = PERIOD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DW-1:0]          wdata_i,
    output logic [DW-1:0]          rdata_o,
    input  logic [NCH-1:0]         hw_clr_i,
    output logic [NCH-1:0]         mode_o,
    output logic [NCH-1:0]         en_o,
    output logic [NCH-1:0]         clr_o,
    output logic [NCH-1:0][PW-1:0] period_o
);

    localparam int HI_W = PW - DW;

    logic                   hit_mode, hit_en, hit_clr;
    logic [NCH-1:0]         mode_q, en_q, clr_q, en_d;
    logic [NCH-1:0][PW-1:0] period_q;
    logic [NCH-1:0][DW-1:0] stage_q;

    assign hit_mode = wr_en_i && (addr_i == ADDR_W'(A_MODE));
    assign hit_en   = wr_en_i && (addr_i == ADDR_W'(A_ENABLE));
    assign hit_clr  = wr_en_i && (addr_i == ADDR_W'(A_RESTART));

    // hardware clear takes precedence over a software write in the same cycle
    assign en_d = (hit_en ? wdata_i[NCH-1:0] : en_q) & ~hw_clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            en_q   <= '0;
            clr_q  <= '0;
        end else begin
            if (hit_mode) begin
                mode_q <= wdata_i[NCH-1:0];
            end
            en_q  <= en_d;
            clr_q <= hit_clr ? wdata_i[NCH-1:0] : '0;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_period
        logic lo_hit, hi_hit;
        assign lo_hit = wr_en_i && (addr_i == ADDR_W'(A_PERBASE + 2 * n));
        assign hi_hit = wr_en_i && (addr_i == ADDR_W'(A_PERBASE + 2 * n + 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[n]  <= '0;
                period_q[n] <= '0;
            end else begin
                if (lo_hit) begin
                    stage_q[n] <= wdata_i;
                end
                if (hi_hit) begin
                    period_q[n] <= {wdata_i[HI_W-1:0], stage_q[n]};
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_MODE)) begin
            rdata_o = {{(DW-NCH){1'b0}}, mode_q};
        end else if (addr_i == ADDR_W'(A_ENABLE)) begin
            rdata_o = {{(DW-NCH){1'b0}}, en_q};
        end else if (addr_i == ADDR_W'(A_RESTART)) begin
            rdata_o = {{(DW-NCH){1'b0}}, clr_q};
        end
        for (int n = 0; n < NCH; n++) begin
            if (addr_i == ADDR_W'(A_PERBASE + 2 * n)) begin
                rdata_o = period_q[n][DW-1:0];
            end
            if (addr_i == ADDR_W'(A_PERBASE + 2 * n + 1)) begin
                rdata_o = {{(DW-HI_W){1'b0}}, period_q[n][PW-1:DW]};
            end
        end
    end

    assign mode_o   = mode_q;
    assign en_o     = en_q;
    assign clr_o    = clr_q;
    assign period_o = period_q;

endmodule

// File: rtl/pwm6_channel.sv
module pwm6_channel
    import pwm6_pkg::*;
#(
    parameter int PW = PERIOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          mode_i,
    input  logic          clr_i,
    input  logic          brake_i,
    input  logic [PW-1:0] period_i,
    output logic          match_o,
    output logic          running_o,
    output logic          done_o
);

    ch_state_e     state_q, state_d;
    logic [PW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == period_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (en_i && !brake_i) begin
                    state_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (brake_i || !en_i) begin
                    state_d = CH_IDLE;
                end else if (!clr_i && at_end && !mode_i) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != CH_RUN || state_d != CH_RUN || clr_i || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        running_o = (state_q == CH_RUN);
        match_o   = running_o && en_i && !clr_i && at_end;
        done_o    = match_o && !mode_i;
    end

endmodule

// File: rtl/pwm6_timebase.sv
module pwm6_timebase
    import pwm6_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 8,
    parameter int DW     = BYTE_W,
    parameter int PW     = PERIOD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic              brake_i,
    output logic [NCH-1:0]    match_o,
    output logic [NCH-1:0]    running_o
);

    logic [NCH-1:0]         mode_w, en_w, clr_w, done_w, hw_clr_w;
    logic [NCH-1:0][PW-1:0] period_w;

    assign hw_clr_w = done_w | {NCH{brake_i}};

    pwm6_regfile #(
        .NCH   (NCH),
        .ADDR_W(ADDR_W),
        .DW    (DW),
        .PW    (PW)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .hw_clr_i(hw_clr_w),
        .mode_o  (mode_w),
        .en_o    (en_w),
        .clr_o   (clr_w),
        .period_o(period_w)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm6_channel #(
            .PW(PW)
        ) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en_w[n]),
            .mode_i   (mode_w[n]),
            .clr_i    (clr_w[n]),
            .brake_i  (brake_i),
            .period_i (period_w[n]),
            .match_o  (match_o[n]),
            .running_o(running_o[n]),
            .done_o   (done_w[n])
        );
    end

endmodule

// File: rtl/pwm6_timebase_chk.sv
module pwm6_timebase_chk
    import pwm6_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 8,
    parameter int DW     = BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DW-1:0]     rdata_o,
    input logic              brake_i,
    input logic [NCH-1:0]    match_o,
    input logic [NCH-1:0]    running_o,
    input logic [NCH-1:0]    mode_w,
    input logic [NCH-1:0]    clr_w
);

    logic ctrl_addr;
    assign ctrl_addr = (addr_i == ADDR_W'(A_MODE)) || (addr_i == ADDR_W'(A_ENABLE))
                    || (addr_i == ADDR_W'(A_RESTART));

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_addr |-> (rdata_o[DW-1:NCH] == '0));

    assert_match_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o & ~running_o) == '0);

    assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((running_o & $past(match_o & ~mode_w)) == '0));

    assert_brake_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brake_i |=> (running_o == '0));

    assert_clear_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w != '0 && !(wr_en_i && addr_i == ADDR_W'(A_RESTART))) |=> (clr_w == '0));

endmodule

bind pwm6_timebase pwm6_timebase_chk #(
    .NCH   (NCH),
    .ADDR_W(ADDR_W),
    .DW    (DW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .brake_i  (brake_i),
    .match_o  (match_o),
    .running_o(running_o),
    .mode_w   (mode_w),
    .clr_w    (clr_w)
);

// File: tb/pwm6_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm6_timebase_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       brake_i = 1'b0;
    logic [5:0] match_o;
    logic [5:0] running_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwm6_timebase dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .brake_i  (brake_i),
        .match_o  (match_o),
        .running_o(running_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
        wdata_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1", "running after reset", 32'(running_o), 0);
        chk("R1", "match after reset", 32'(match_o), 0);
        rd(8'h00, d); chk("R1", "mode reset", 32'(d), 0);
        rd(8'h01, d); chk("R1", "enable reset", 32'(d), 0);
        rd(8'h02, d); chk("R1", "restart reset", 32'(d), 0);
        rd(8'h1B, d); chk("R1", "period ch5 hi reset", 32'(d), 0);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        wr(8'h00, 8'hFF);
        rd(8'h00, d); chk("R1", "mode reserved bits", 32'(d), 32'h3F);
        wr(8'h00, 8'h00);
        wr(8'h01, 8'hC0);
        rd(8'h01, d); chk("R1", "enable reserved bits", 32'(d), 0);
        chk("R1", "no channel from reserved bits", 32'(running_o), 0);
    endtask

    task automatic t_autoreload;
        logic [7:0] d;
        wr(8'h10, 8'd3);
        rd(8'h10, d); chk("R9", "low byte staged", 32'(d), 0);
        wr(8'h11, 8'd0);
        rd(8'h10, d); chk("R9", "low byte committed", 32'(d), 3);
        wr(8'h00, 8'h01);
        wr(8'h01, 8'h01);
        chk("R3", "running not yet", 32'(running_o[0]), 0);
        tick(1);
        chk("R3", "running rises", 32'(running_o[0]), 1);
        chk("R4", "no match at count 0", 32'(match_o[0]), 0);
        tick(2);
        chk("R4", "no match at count 2", 32'(match_o[0]), 0);
        tick(1);
        chk("R4", "match at count 3", 32'(match_o[0]), 1);
        tick(1);
        chk("R4", "match one cycle", 32'(match_o[0]), 0);
        chk("R2", "still running after wrap", 32'(running_o[0]), 1);
        tick(3);
        chk("R2", "second match after P+1", 32'(match_o[0]), 1);
        wr(8'h01, 8'h00);
        chk("R6", "match suppressed on disable", 32'(match_o[0]), 0);
        tick(1);
        chk("R6", "running falls", 32'(running_o[0]), 0);
        wr(8'h01, 8'h01);
        tick(1);
        tick(2);
        chk("R6", "restart from 0, no early match", 32'(match_o[0]), 0);
        tick(1);
        chk("R6", "restart from 0, match on time", 32'(match_o[0]), 1);
        wr(8'h01, 8'h00);
        tick(1);
    endtask

    task automatic t_oneshot;
        logic [7:0] d;
        wr(8'h12, 8'd2);
        wr(8'h13, 8'd0);
        wr(8'h01, 8'h02);
        tick(1);
        chk("R5", "one-shot running", 32'(running_o[1]), 1);
        tick(2);
        chk("R5", "one-shot match", 32'(match_o[1]), 1);
        tick(1);
        chk("R5", "one-shot stops", 32'(running_o[1]), 0);
        rd(8'h01, d); chk("R5", "enable cleared by hardware", 32'(d), 0);
        tick(4);
        chk("R5", "no further match", 32'(match_o[1]), 0);
    endtask

    task automatic t_zero;
        wr(8'h00, 8'h05);
        wr(8'h01, 8'h04);
        tick(1);
        chk("R10", "match with period 0", 32'(match_o[2]), 1);
        for (int i = 0; i < 3; i++) begin
            tick(1);
            chk("R10", "match every cycle", 32'(match_o[2]), 1);
        end
        wr(8'h01, 8'h00);
        tick(1);
    endtask

    task automatic t_restart;
        logic [7:0] d;
        wr(8'h10, 8'd5);
        wr(8'h11, 8'd0);
        wr(8'h01, 8'h01);
        tick(1);
        tick(3);
        wr(8'h02, 8'h01);
        rd(8'h02, d); chk("R8", "restart bit reads 1", 32'(d), 1);
        tick(1);
        rd(8'h02, d); chk("R8", "restart bit self-clears", 32'(d), 0);
        tick(4);
        chk("R8", "match delayed by restart", 32'(match_o[0]), 0);
        tick(1);
        chk("R8", "match after restart", 32'(match_o[0]), 1);
        wr(8'h02, 8'h00);
        tick(4);
        chk("R8", "write 0 keeps schedule (early)", 32'(match_o[0]), 0);
        tick(1);
        chk("R8", "write 0 keeps schedule", 32'(match_o[0]), 1);
        wr(8'h01, 8'h00);
        tick(1);
    endtask

    task automatic t_brake;
        logic [7:0] d;
        wr(8'h01, 8'h05);
        tick(1);
        chk("R7", "channels running before brake", 32'(running_o), 32'h05);
        brake_i = 1'b1;
        tick(1);
        chk("R7", "brake stops all", 32'(running_o), 0);
        rd(8'h01, d); chk("R7", "brake clears enables", 32'(d), 0);
        wr(8'h01, 8'h3F);
        rd(8'h01, d); chk("R7", "enable write lost under brake", 32'(d), 0);
        brake_i = 1'b0;
        tick(1);
        chk("R7", "still stopped after brake", 32'(running_o), 0);
    endtask

    task automatic t_race;
        logic [7:0] d;
        wr(8'h01, 8'h02);
        tick(1);
        tick(2);
        chk("R11", "one-shot match", 32'(match_o[1]), 1);
        wr(8'h01, 8'h02);
        rd(8'h01, d); chk("R11", "hardware clear wins", 32'(d), 0);
        tick(1);
        chk("R11", "channel stopped", 32'(running_o[1]), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_reserved();
        t_autoreload();
        t_oneshot();
        t_zero();
        t_restart();
        t_brake();
        t_race();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule